// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the entry sequence of a small 8-bit accumulator CPU for four triggers: power-on reset, a non-maskable request on an edge-sensitive pin, a maskable request on a level-sensitive pin, and a software break opcode reported by the decoder. Every trigger uses the same seven bus cycles. The sequence saves the program counter and status on the stack in memory page one and then loads a new program counter from a two-byte vector near the top of the address space. The CPU core supplies the current PC, status byte and stack pointer. It also raises a strobe at the end of each instruction. The sequencer then owns the bus for seven cycles. In the last cycle it returns the new PC and a request to set the interrupt-disable bit. The stack pointer value it hands back is already decremented three times.

The choice of vector is left as late as possible. It is made in cycle 5, when the low vector byte is read. A non-maskable request that becomes pending while a break or maskable entry is still in cycles 0 to 4 takes over that same sequence, so its handler is entered without a second entry. A request that first becomes pending during the two vector reads is discarded.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset is released, a reset sequence starts without waiting for an instruction boundary. It fetches its vector from 0xFFFC/0xFFFD. Its three stack cycles are reads (bus_wr stays 0), but sp_out still ends three lower than sp_in.
- R2: Every entry keeps bus_act high for exactly seven cycles, numbered 0 to 6. done is high only in cycle 6. A trigger presented while a sequence is running does not restart it.
- R3: A new sequence starts only on a clock edge where insn_end is high, apart from the reset sequence of R1. A pending request waits while insn_end is low.
- R4: Cycles 0 and 1 read at the PC. Cycles 2, 3 and 4 write PC high byte, PC low byte and status to 0x0100+SP, 0x0100+SP-1 and 0x0100+SP-2, in that order. The stack pointer drops by one after each of these cycles.
- R5: The pushed status is p_in as sampled at the starting boundary, with bit 5 forced to 1. Bit 4 is 1 only for a break entry. The interrupt-disable bit (bit 2) keeps its old value.
- R6: set_imask is high only in cycle 6, after the status push.
- R7: Cycle 5 reads 0xFFFA for a non-maskable entry and 0xFFFE for a maskable or break entry. Cycle 6 reads the next address. pc_out in cycle 6 is {rdata, byte read in cycle 5}. When both are pending at a boundary, the non-maskable request wins over the maskable one.
- R8: A non-maskable request that becomes pending during cycles 0 to 4 of a break or maskable entry redirects that sequence to 0xFFFA. The request is then consumed and causes no second entry.
- R9: A non-maskable request that becomes pending only during cycles 5 and 6 changes nothing and is never serviced.
- R10: nmi_n must be sampled low on two consecutive clock edges to count. A one-cycle low pulse is ignored.
- R11: The maskable request is ignored while p_in bit 2 is 1. The non-maskable pin needs a new high-to-low transition for each request, so holding it low does not retrigger.
- R12: If irq_n is still low and p_in bit 2 has been cleared, the next boundary after an entry starts another maskable entry. This allows nesting inside a handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_end | input | 1 | Instruction boundary strobe from the core |
| brk_op | input | 1 | Break opcode decoded, valid with insn_end |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, edge |
| pc_in | input | 16 | Current program counter |
| p_in | input | 8 | Current status byte (bit 2 = interrupt disable) |
| sp_in | input | 8 | Current stack pointer |
| rdata | input | 8 | Bus read data |
| bus_act | output | 1 | Sequencer owns the bus this cycle |
| bus_wr | output | 1 | 1 = write cycle, 0 = read cycle |
| addr | output | 16 | Bus address |
| wdata | output | 8 | Bus write data |
| pc_out | output | 16 | New program counter, valid with done |
| sp_out | output | 8 | Stack pointer after the pushes |
| set_imask | output | 1 | Set interrupt-disable in the core |
| done | output | 1 | Last cycle of the sequence |

## Verification
The bench aims at the timing of a non-maskable pulse against a break entry in progress. A pulse placed in cycle 2 must take over the vector. A design that chose the vector at the start would fetch 0xFFFE, and one that kept the request would run a second entry afterwards. A pulse one cycle later must be dropped, which catches designs that service it once the sequence ends. The bench also checks three other cases: one-cycle glitches, a level held low that must not retrigger, and the old interrupt-disable bit in the pushed status, which a design that sets the mask too early would corrupt. Reset entries are checked for pushes turned into reads, and nesting is checked to restart only on a boundary.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    ST_OPC = 3'd0,
    ST_DUM = 3'd1,
    ST_PCH = 3'd2,
    ST_PCL = 3'd3,
    ST_PSW = 3'd4,
    ST_VLO = 3'd5,
    ST_VHI = 3'd6
  } step_e;

  typedef enum logic [1:0] {
    K_RST = 2'd0,
    K_NMI = 2'd1,
    K_IRQ = 2'd2,
    K_BRK = 2'd3
  } kind_e;

  localparam int IMASK_BIT = 2;
  localparam int BRKF_BIT  = 4;
  localparam int ONE_BIT   = 5;

endpackage

// File: rtl/irq_nmi_detect.sv
module irq_nmi_detect #(
  parameter int QUAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  output logic edge_o
);
  logic [QUAL-1:0] smp_q, smp_d;
  logic            act_q, act;

  // pin counts as active once QUAL successive samples are low
  generate
    if (QUAL == 1) begin : g_one
      assign smp_d = nmi_n;
    end else begin : g_many
      assign smp_d = {smp_q[QUAL-2:0], nmi_n};
    end
  endgenerate

  assign act    = ~|smp_q;
  assign edge_o = act & ~act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '1;
      act_q <= 1'b0;
    end else begin
      smp_q <= smp_d;
      act_q <= act;
    end
  end
endmodule

// File: rtl/irq_vec_pick.sv
module irq_vec_pick import irq_seq_pkg::*; #(
  parameter int              AW      = 16,
  parameter logic [AW-1:0]   VEC_NMI = 16'hFFFA,
  parameter logic [AW-1:0]   VEC_RST = 16'hFFFC,
  parameter logic [AW-1:0]   VEC_IRQ = 16'hFFFE
) (
  input  kind_e         kind,
  input  logic          nmi_pend,
  output logic [AW-1:0] vec
);
  // reset outranks everything; a pending NMI outranks the started kind
  always_comb begin
    if (kind == K_RST)                      vec = VEC_RST;
    else if (kind == K_NMI || nmi_pend)     vec = VEC_NMI;
    else                                    vec = VEC_IRQ;
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq import irq_seq_pkg::*; #(
  parameter int DW       = 8,
  parameter int NMI_QUAL = 2,
  parameter logic [DW-1:0]   STACK_PAGE = 8'h01,
  parameter logic [2*DW-1:0] VEC_NMI    = 16'hFFFA,
  parameter logic [2*DW-1:0] VEC_RST    = 16'hFFFC,
  parameter logic [2*DW-1:0] VEC_IRQ    = 16'hFFFE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_end,
  input  logic            brk_op,
  input  logic            irq_n,
  input  logic            nmi_n,
  input  logic [2*DW-1:0] pc_in,
  input  logic [DW-1:0]   p_in,
  input  logic [DW-1:0]   sp_in,
  input  logic [DW-1:0]   rdata,
  output logic            bus_act,
  output logic            bus_wr,
  output logic [2*DW-1:0] addr,
  output logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] pc_out,
  output logic [DW-1:0]   sp_out,
  output logic            set_imask,
  output logic            done
);
  localparam int AW = 2 * DW;

  logic          busy_q, busy_d;
  step_e         step_q, step_d;
  kind_e         kind_q, kind_d, start_kind;
  logic [AW-1:0] pc_q, pc_d, vbase_q, vbase_d, vec_sel;
  logic [DW-1:0] p_q, p_d, sp_q, sp_d, vlo_q, vlo_d, psw_push;
  logic          nmi_pend_q, nmi_pend_d, rst_pend_q, rst_pend_d;
  logic          nmi_edge, irq_ok, start, late_win;

  irq_nmi_detect #(.QUAL(NMI_QUAL)) i_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .edge_o(nmi_edge)
  );

  irq_vec_pick #(.AW(AW), .VEC_NMI(VEC_NMI), .VEC_RST(VEC_RST),
                 .VEC_IRQ(VEC_IRQ)) i_vec (
    .kind(kind_q), .nmi_pend(nmi_pend_q), .vec(vec_sel)
  );

  assign irq_ok = ~irq_n & ~p_in[IMASK_BIT];
  assign start  = ~busy_q & (rst_pend_q |
                  (insn_end & (nmi_pend_q | irq_ok | brk_op)));

  always_comb begin
    if (rst_pend_q)      start_kind = K_RST;
    else if (nmi_pend_q) start_kind = K_NMI;
    else if (irq_ok)     start_kind = K_IRQ;
    else                 start_kind = K_BRK;
  end

  // vector fetch cycles: a fresh NMI seen here is dropped
  assign late_win = busy_q & (step_q == ST_VLO || step_q == ST_VHI);

  always_comb begin
    busy_d     = busy_q;
    step_d     = step_q;
    kind_d     = kind_q;
    pc_d       = pc_q;
    p_d        = p_q;
    sp_d       = sp_q;
    vlo_d      = vlo_q;
    vbase_d    = vbase_q;
    rst_pend_d = rst_pend_q;
    nmi_pend_d = nmi_pend_q;
    if (start) begin
      busy_d = 1'b1;
      step_d = ST_OPC;
      kind_d = start_kind;
      pc_d   = pc_in;
      p_d    = p_in;
      sp_d   = sp_in;
      if (start_kind == K_RST) rst_pend_d = 1'b0;
    end else if (busy_q) begin
      if (step_q == ST_VHI) busy_d = 1'b0;
      else                  step_d = step_e'(step_q + 3'd1);
      if (step_q == ST_PCH || step_q == ST_PCL || step_q == ST_PSW)
        sp_d = sp_q - 1'b1;
      if (step_q == ST_VLO) begin
        vlo_d   = rdata;
        vbase_d = vec_sel;
      end
    end
    if (busy_q && step_q == ST_VLO && kind_q != K_RST) nmi_pend_d = 1'b0;
    if (nmi_edge && !late_win) nmi_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      step_q     <= ST_OPC;
      kind_q     <= K_RST;
      pc_q       <= '0;
      p_q        <= '0;
      sp_q       <= '0;
      vlo_q      <= '0;
      vbase_q    <= '0;
      rst_pend_q <= 1'b1;
      nmi_pend_q <= 1'b0;
    end else begin
      busy_q     <= busy_d;
      step_q     <= step_d;
      kind_q     <= kind_d;
      pc_q       <= pc_d;
      p_q        <= p_d;
      sp_q       <= sp_d;
      vlo_q      <= vlo_d;
      vbase_q    <= vbase_d;
      rst_pend_q <= rst_pend_d;
      nmi_pend_q <= nmi_pend_d;
    end
  end

  // status image: break flag read in the push cycle itself
  always_comb begin
    psw_push           = p_q;
    psw_push[ONE_BIT]  = 1'b1;
    psw_push[BRKF_BIT] = (kind_q == K_BRK);
  end

  always_comb begin
    addr   = pc_q;
    wdata  = '0;
    bus_wr = 1'b0;
    if (busy_q) begin
      case (step_q)
        ST_PCH: begin
          addr = {STACK_PAGE, sp_q}; wdata = pc_q[AW-1:DW];
          bus_wr = (kind_q != K_RST);
        end
        ST_PCL: begin
          addr = {STACK_PAGE, sp_q}; wdata = pc_q[DW-1:0];
          bus_wr = (kind_q != K_RST);
        end
        ST_PSW: begin
          addr = {STACK_PAGE, sp_q}; wdata = psw_push;
          bus_wr = (kind_q != K_RST);
        end
        ST_VLO:  addr = vec_sel;
        ST_VHI:  addr = vbase_q + 1'b1;
        default: addr = pc_q;
      endcase
    end
  end

  assign bus_act   = busy_q;
  assign done      = busy_q & (step_q == ST_VHI);
  assign set_imask = done;
  assign pc_out    = {rdata, vlo_q};
  assign sp_out    = sp_q;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_act,
  input logic            bus_wr,
  input logic [2*DW-1:0] addr,
  input logic [DW-1:0]   sp_out,
  input logic            set_imask,
  input logic            done
);
  logic [2:0] cnt_q;
  logic       first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else begin
      cnt_q <= bus_act ? cnt_q + 3'd1 : 3'd0;
      if (done) first_q <= 1'b0;
    end
  end

  // R2: done lands exactly on the seventh active cycle
  p_done_cycle6_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_act && cnt_q == 3'd6));
  // R2: bus released after cycle 6
  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && cnt_q == 3'd6) |=> !bus_act);
  // R1: first sequence after reset never writes
  p_reset_reads_r1: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |-> !bus_wr);
  // R4: writes only hit the stack page
  p_push_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> addr[2*DW-1:DW] == 8'h01);
  // R4: stack pointer steps down after each push cycle
  p_sp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && cnt_q >= 3'd2 && cnt_q <= 3'd4) |=> sp_out == $past(sp_out) - 1'b1);
  // R6: mask set only in the final cycle
  p_imask_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_imask |-> done);
  // R7: high vector byte read from the following address
  p_vec_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> addr == $past(addr) + 1'b1);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_act(bus_act), .bus_wr(bus_wr),
  .addr(addr), .sp_out(sp_out), .set_imask(set_imask), .done(done)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n, insn_end, brk_op, irq_n, nmi_n;
  logic [15:0] pc_in, addr, pc_out;
  logic [7:0]  p_in, sp_in, rdata, wdata, sp_out;
  logic        bus_act, bus_wr, set_imask, done;

  int checks = 0;
  int failures = 0;

  logic [15:0] cap_addr [7];
  logic        cap_wr   [7];
  logic [7:0]  cap_wd   [7];
  logic        cap_done [7];
  logic        cap_im   [7];
  logic [15:0] pc_got;
  logic        got, after_act;

  always #2.5 clk = ~clk;

  always_comb begin
    case (addr)
      16'hFFFA: rdata = 8'h34;
      16'hFFFB: rdata = 8'h12;
      16'hFFFC: rdata = 8'h78;
      16'hFFFD: rdata = 8'h56;
      16'hFFFE: rdata = 8'hBC;
      16'hFFFF: rdata = 8'h9A;
      default:  rdata = 8'h00;
    endcase
  end

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .brk_op(brk_op),
    .irq_n(irq_n), .nmi_n(nmi_n), .pc_in(pc_in), .p_in(p_in),
    .sp_in(sp_in), .rdata(rdata), .bus_act(bus_act), .bus_wr(bus_wr),
    .addr(addr), .wdata(wdata), .pc_out(pc_out), .sp_out(sp_out),
    .set_imask(set_imask), .done(done)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // waits for a sequence (bounded), records 7 cycles; optional NMI pulse
  task automatic capture(input int nmi_at, input int nmi_len);
    int w = 0;
    do begin
      @(negedge clk);
      insn_end = 1'b0;
      brk_op   = 1'b0;
      w++;
    end while (!bus_act && w < 20);
    got = bus_act;
    if (got) begin
      for (int i = 0; i < 7; i++) begin
        cap_addr[i] = addr;
        cap_wr[i]   = bus_wr;
        cap_wd[i]   = wdata;
        cap_done[i] = done;
        cap_im[i]   = set_imask;
        if (i == 6) pc_got = pc_out;
        if (i == nmi_at) nmi_n = 1'b0;
        if (nmi_at >= 0 && i == nmi_at + nmi_len) nmi_n = 1'b1;
        if (i < 6) @(negedge clk);
      end
      @(negedge clk);
      after_act = bus_act;
    end
  endtask

  task automatic boundary(input logic brk);
    @(negedge clk);
    insn_end = 1'b1;
    brk_op   = brk;
  endtask

  task automatic check_pushes(input string req, input logic [7:0] psw);
    chk(req, "cyc0 addr", cap_addr[0], 16'h4321);
    chk(req, "cyc1 addr", cap_addr[1], 16'h4321);
    chk(req, "pch addr",  cap_addr[2], 16'h01F0);
    chk(req, "pch data",  {cap_wr[2], cap_wd[2]}, {1'b1, 8'h43});
    chk(req, "pcl addr",  cap_addr[3], 16'h01EF);
    chk(req, "pcl data",  {cap_wr[3], cap_wd[3]}, {1'b1, 8'h21});
    chk(req, "psw addr",  cap_addr[4], 16'h01EE);
    chk(req, "psw data",  {cap_wr[4], cap_wd[4]}, {1'b1, psw});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; insn_end = 1'b0; brk_op = 1'b0; irq_n = 1'b1; nmi_n = 1'b1;
    pc_in = 16'h4321; p_in = 8'h01; sp_in = 8'hFD;
    repeat (3) @(negedge clk);
    chk("R1", "reset bus_act", bus_act, 1'b0);
    chk("R1", "reset done", done, 1'b0);
    rst_n = 1'b1;
    capture(-1, 0);
    chk("R1", "reset seq started", got, 1'b1);
    chk("R1", "no writes", {cap_wr[2], cap_wr[3], cap_wr[4]}, 3'b000);
    chk("R1", "vector lo addr", cap_addr[5], 16'hFFFC);
    chk("R1", "new pc", pc_got, 16'h5678);
    chk("R1", "sp after", sp_out, 8'hFA);
    chk("R2", "done at cyc6", {cap_done[5], cap_done[6]}, 2'b01);
  endtask

  task automatic t_irq_basic;
    sp_in = 8'hF0; p_in = 8'h01; irq_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3", "no start without boundary", bus_act, 1'b0);
    boundary(1'b0);
    capture(-1, 0);
    chk("R3", "irq taken at boundary", got, 1'b1);
    check_pushes("R4", 8'h21);
    chk("R5", "old I and B=0", cap_wd[4], 8'h21);
    chk("R6", "imask timing", {cap_im[4], cap_im[5], cap_im[6]}, 3'b001);
    chk("R7", "irq vector", {cap_addr[5], cap_addr[6]}, {16'hFFFE, 16'hFFFF});
    chk("R7", "irq pc", pc_got, 16'h9ABC);
    chk("R4", "sp after", sp_out, 8'hED);
    chk("R2", "released", after_act, 1'b0);
    irq_n = 1'b1;
  endtask

  task automatic t_brk;
    p_in = 8'h05;
    boundary(1'b1);
    capture(-1, 0);
    chk("R5", "brk psw keeps old I, B=1", cap_wd[4], 8'h35);
    chk("R7", "brk vector", cap_addr[5], 16'hFFFE);
    p_in = 8'h01;
  endtask

  task automatic t_mask;
    p_in = 8'h04; irq_n = 1'b0;
    boundary(1'b0);
    capture(-1, 0);
    chk("R11", "masked irq ignored", got, 1'b0);
    irq_n = 1'b1; p_in = 8'h01;
  endtask

  task automatic t_glitch;
    @(negedge clk); nmi_n = 1'b0;
    @(negedge clk); nmi_n = 1'b1;
    repeat (3) @(negedge clk);
    boundary(1'b0);
    capture(-1, 0);
    chk("R10", "glitch ignored", got, 1'b0);
  endtask

  task automatic t_nmi_priority;
    @(negedge clk); nmi_n = 1'b0;
    repeat (3) @(negedge clk);
    irq_n = 1'b0;
    boundary(1'b0);
    capture(-1, 0);
    chk("R7", "nmi beats irq", cap_addr[5], 16'hFFFA);
    chk("R7", "nmi pc", pc_got, 16'h1234);
    chk("R5", "nmi B=0", cap_wd[4][4], 1'b0);
    irq_n = 1'b1;
    boundary(1'b0);
    capture(-1, 0);
    chk("R11", "held nmi no retrigger", got, 1'b0);
    nmi_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_hijack;
    boundary(1'b1);
    capture(2, 20);
    chk("R8", "hijack vector", {cap_addr[5], cap_addr[6]}, {16'hFFFA, 16'hFFFB});
    chk("R8", "hijack pc", pc_got, 16'h1234);
    chk("R8", "brk flag still pushed", cap_wd[4], 8'h31);
    nmi_n = 1'b1;
    repeat (3) @(negedge clk);
    boundary(1'b0);
    capture(-1, 0);
    chk("R8", "no second entry", got, 1'b0);
  endtask

  task automatic t_late;
    boundary(1'b1);
    capture(3, 20);
    chk("R9", "late nmi keeps vector", cap_addr[5], 16'hFFFE);
    chk("R9", "late nmi pc", pc_got, 16'h9ABC);
    nmi_n = 1'b1;
    repeat (3) @(negedge clk);
    boundary(1'b0);
    capture(-1, 0);
    chk("R9", "late nmi never serviced", got, 1'b0);
  endtask

  task automatic t_nest;
    p_in = 8'h01; irq_n = 1'b0;
    boundary(1'b0);
    capture(-1, 0);
    chk("R12", "first entry", got, 1'b1);
    chk("R12", "no restart without boundary", after_act, 1'b0);
    boundary(1'b0);
    capture(-1, 0);
    chk("R12", "nested entry", got, 1'b1);
    chk("R12", "nested vector", cap_addr[5], 16'hFFFE);
    irq_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_irq_basic();
    t_brk();
    t_mask();
    t_glitch();
    t_nmi_priority();
    t_hijack();
    t_late();
    t_nest();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule